// File: doc/BRIEF.md
# Banked Two-Clock Memory with Switchable Read Path

This block is a simple dual-port memory built by stacking several 256-entry, 18-bit storage banks in depth. A write port and a read port sit on separate, unrelated clocks. A write stores one word on a write-clock edge. The address bits above the bank index field pick which single bank receives the write.

The read port has a mode input. With the mode low, a read is captured into output registers on a read-clock edge, and the read enable acts as the capture enable. With the mode high, the output is a combinational lookup of the addressed word. In that mode the read enable gates the output, which reads zero when the enable is low. On both paths a multiplexer steered by the upper read-address bits selects the bank whose word reaches the output.

Top module: `cascaded_dcram`

## Requirements
- R1: After reset, with the mode input low (registered read), rd_data reads zero until the first enabled capture.
- R2: A word is stored on a rising wr_clk edge only when wr_en is high. With wr_en low, the addressed word keeps its old content.
- R3: wr_addr[9:8] (the bits above the 8-bit in-bank index) select exactly one bank for each write. The same in-bank index in the other banks is left unchanged.
- R4: With rd_async low and rd_en high at a rising rd_clk edge, rd_data shows the word at rd_addr from that edge onward. Reads work in every bank.
- R5: With rd_async low and rd_en low at a rd_clk edge, rd_data holds its previous value.
- R6: With rd_async high and rd_en high, rd_data follows rd_addr combinationally, with no rd_clk edge needed.
- R7: With rd_async high and rd_en low, rd_data is zero.
- R8: In registered mode, the bank select (rd_addr[9:8]) is captured together with the data. Changing rd_addr after a capture, including to another bank, leaves rd_data unchanged while rd_en stays low.
- R9: When both clocks share an edge and a registered read hits the address being written, the read returns the old word. A later read returns the new word.
- R10: Reads in combinational mode do not update the capture registers. Switching back to registered mode shows the last registered capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write enable, used as a clock enable |
| wr_addr | input | 10 | Write address; bits 9:8 pick the bank |
| wr_data | input | 18 | Write data |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for the read registers |
| rd_en | input | 1 | Read enable: capture enable, or output gate in combinational mode |
| rd_async | input | 1 | 1 = combinational read, 0 = registered read |
| rd_addr | input | 10 | Read address; bits 9:8 pick the bank |
| rd_data | output | 18 | Read data |

## Verification
On every cycle, the assertions check several properties. At most one bank's write enable is active, and exactly one is active when a write is requested. In combinational mode with the enable low, the output is zero. In registered mode with the enable low, both the output and the registered bank select hold their values. Only the bench scenarios can show that stored contents are right. Those scenarios cover which bank a write lands in, old data returned on a same-edge collision, and a registered value surviving a spell of combinational reads. The bench compares all of these against a reference array while the two clocks run at unrelated periods.

// File: rtl/dcram_pkg.sv
package dcram_pkg;
  // In-bank index width; one bank holds 2**BANK_AW words.
  localparam int unsigned BANK_AW_DEF = 8;
  // Word width of every bank.
  localparam int unsigned WORD_W_DEF  = 18;
  // Number of banks stacked in depth (power of two, at least 2).
  localparam int unsigned BANKS_DEF   = 4;
endpackage

// File: rtl/dcram_bank.sv
module dcram_bank #(
  parameter int unsigned BANK_AW = dcram_pkg::BANK_AW_DEF,
  parameter int unsigned DW      = dcram_pkg::WORD_W_DEF
) (
  input  logic               wclk,
  input  logic               we,
  input  logic [BANK_AW-1:0] waddr,
  input  logic [DW-1:0]      wdata,
  input  logic               rclk,
  input  logic               rst_n,
  input  logic               cap_en,
  input  logic [BANK_AW-1:0] raddr,
  output logic [DW-1:0]      rd_comb,
  output logic [DW-1:0]      rd_q
);
  localparam int unsigned WORDS = 1 << BANK_AW;

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] rd_q_d;

  // Storage: write only when this bank is enabled.
  always_ff @(posedge wclk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Combinational lookup feeds both read paths.
  always_comb begin
    rd_comb = mem[raddr];
  end

  // Capture register next state.
  always_comb begin
    rd_q_d = rd_q;
    if (cap_en) begin
      rd_q_d = rd_comb;
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_q_d;
    end
  end
endmodule

// File: rtl/dcram_wr_decode.sv
module dcram_wr_decode #(
  parameter int unsigned BANKS = dcram_pkg::BANKS_DEF,
  localparam int unsigned SEL_W = $clog2(BANKS)
) (
  input  logic             we,
  input  logic [SEL_W-1:0] bank_sel,
  output logic [BANKS-1:0] bank_we
);
  for (genvar b = 0; b < BANKS; b++) begin : g_dec
    always_comb begin
      bank_we[b] = we && (bank_sel == SEL_W'(b));
    end
  end
endmodule

// File: rtl/dcram_rd_select.sv
module dcram_rd_select #(
  parameter int unsigned BANKS = dcram_pkg::BANKS_DEF,
  parameter int unsigned DW    = dcram_pkg::WORD_W_DEF,
  localparam int unsigned SEL_W = $clog2(BANKS)
) (
  input  logic [BANKS-1:0][DW-1:0] bank_comb,
  input  logic [BANKS-1:0][DW-1:0] bank_q,
  input  logic [SEL_W-1:0]         sel_now,
  input  logic [SEL_W-1:0]         sel_q,
  input  logic                     async_mode,
  input  logic                     re,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] sync_word;
  logic [DW-1:0] flow_word;

  always_comb begin
    sync_word = bank_q[sel_q];
    flow_word = bank_comb[sel_now];
    if (async_mode) begin
      rdata = re ? flow_word : '0;
    end else begin
      rdata = sync_word;
    end
  end
endmodule

// File: rtl/cascaded_dcram.sv
module cascaded_dcram #(
  parameter int unsigned BANKS   = dcram_pkg::BANKS_DEF,
  parameter int unsigned BANK_AW = dcram_pkg::BANK_AW_DEF,
  parameter int unsigned DW      = dcram_pkg::WORD_W_DEF,
  localparam int unsigned SEL_W  = $clog2(BANKS),
  localparam int unsigned AW     = BANK_AW + SEL_W
) (
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          rd_async,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [1:0]               rst_sync;
  logic                     rd_rst_n;
  logic [BANKS-1:0]         bank_we;
  logic [BANKS-1:0][DW-1:0] bank_comb;
  logic [BANKS-1:0][DW-1:0] bank_q;
  logic                     cap_en;
  logic [SEL_W-1:0]         sel_q;
  logic [SEL_W-1:0]         sel_q_d;

  // Reset: asserted asynchronously, released on the read clock.
  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rd_rst_n = rst_sync[1];

  // Capture only in registered mode.
  assign cap_en = rd_en && !rd_async;

  dcram_wr_decode #(.BANKS(BANKS)) u_wdec (
    .we      (wr_en),
    .bank_sel(wr_addr[AW-1:BANK_AW]),
    .bank_we (bank_we)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    dcram_bank #(.BANK_AW(BANK_AW), .DW(DW)) u_bank (
      .wclk   (wr_clk),
      .we     (bank_we[b]),
      .waddr  (wr_addr[BANK_AW-1:0]),
      .wdata  (wr_data),
      .rclk   (rd_clk),
      .rst_n  (rd_rst_n),
      .cap_en (cap_en),
      .raddr  (rd_addr[BANK_AW-1:0]),
      .rd_comb(bank_comb[b]),
      .rd_q   (bank_q[b])
    );
  end

  // Bank select register, captured alongside the bank data.
  always_comb begin
    sel_q_d = sel_q;
    if (cap_en) begin
      sel_q_d = rd_addr[AW-1:BANK_AW];
    end
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      sel_q <= '0;
    end else begin
      sel_q <= sel_q_d;
    end
  end

  dcram_rd_select #(.BANKS(BANKS), .DW(DW)) u_rsel (
    .bank_comb (bank_comb),
    .bank_q    (bank_q),
    .sel_now   (rd_addr[AW-1:BANK_AW]),
    .sel_q     (sel_q),
    .async_mode(rd_async),
    .re        (rd_en),
    .rdata     (rd_data)
  );
endmodule

// File: rtl/dcram_chk.sv
module dcram_chk #(
  parameter int unsigned BANKS = 4,
  parameter int unsigned DW    = 18,
  localparam int unsigned SEL_W = $clog2(BANKS)
) (
  input logic             wclk,
  input logic             rclk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic             rd_async,
  input logic [DW-1:0]    rd_data,
  input logic [BANKS-1:0] bank_we,
  input logic [SEL_W-1:0] sel_q
);
  a_r3_one_bank_max: assert property (@(posedge wclk) disable iff (!rst_n)
    $onehot0(bank_we));

  a_r3_one_bank_on_write: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_en |-> ($countones(bank_we) == 1));

  a_r7_gated_zero: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_async && !rd_en) |-> (rd_data == '0));

  a_r5_sync_hold: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rd_async && !rd_en) |=> (rd_async || $stable(rd_data)));

  a_r8_select_hold: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rd_en) |=> $stable(sel_q));
endmodule

bind cascaded_dcram dcram_chk #(.BANKS(BANKS), .DW(DW)) u_chk (
  .wclk    (wr_clk),
  .rclk    (rd_clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .rd_async(rd_async),
  .rd_data (rd_data),
  .bank_we (bank_we),
  .sel_q   (sel_q)
);

// File: tb/cascaded_dcram_tb.sv
module cascaded_dcram_tb;
  localparam int AW = 10;
  localparam int DW = 18;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 1'b0;
  logic free_rclk = 1'b0;
  logic lockstep = 1'b0;
  logic rd_clk;
  logic rst_n, wr_en, rd_en, rd_async;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;

  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] exp_sync;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 wr_clk = ~wr_clk;
  always #7 free_rclk = ~free_rclk;
  assign rd_clk = lockstep ? wr_clk : free_rclk;

  cascaded_dcram u_dut (
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .rd_async(rd_async),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] flow_expect(input logic en, input logic [AW-1:0] a);
    return en ? model[a] : '0;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: rd_data=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(input logic en, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(posedge wr_clk);
    #1;
    if (en) model[a] = d;
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic sync_read(input logic [AW-1:0] a, input string req);
    @(negedge rd_clk);
    rd_async = 1'b0; rd_en = 1'b1; rd_addr = a;
    @(posedge rd_clk);
    exp_sync = model[a];
    @(negedge rd_clk);
    rd_en = 1'b0;
    check(req, rd_data, exp_sync);
  endtask

  task automatic flow_read(input logic en, input logic [AW-1:0] a, input string req);
    @(negedge rd_clk);
    rd_async = 1'b1; rd_en = en; rd_addr = a;
    #1;
    check(req, rd_data, flow_expect(en, a));
  endtask

  initial begin
    #5ms;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_0017;
    void'($urandom(seed));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; rd_async = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (4) @(posedge free_rclk);
    rst_n = 1'b1;
    repeat (4) @(posedge free_rclk);
    @(negedge rd_clk);
    check("R1 reset output zero", rd_data, '0);

    // Fill every word so the reference array is fully known (R2).
    for (int i = 0; i < DEPTH; i++) do_write(1'b1, AW'(i), DW'($urandom));

    // R2: disabled write leaves the word unchanged.
    do_write(1'b0, 10'd37, 18'h2aaaa);
    sync_read(10'd37, "R2 disabled write ignored");

    // R3: same in-bank index, bank 2 written, other banks untouched.
    do_write(1'b1, 10'h205, 18'h1234a);
    for (int b = 0; b < 4; b++) sync_read(AW'((b << 8) | 5), "R3 bank decode");

    // R4: registered read at the bank edges.
    sync_read(10'h0ff, "R4 last word bank 0");
    sync_read(10'h100, "R4 first word bank 1");
    sync_read(10'h3ff, "R4 top word");

    // R5 / R8: hold with enable low while the address moves to another bank.
    sync_read(10'h3f0, "R4 capture bank 3");
    @(negedge rd_clk); rd_addr = 10'h010;
    repeat (3) @(negedge rd_clk);
    check("R5 R8 hold after address change", rd_data, exp_sync);

    // R6 / R7: combinational path.
    flow_read(1'b1, 10'h1c3, "R6 flow read bank 1");
    flow_read(1'b1, 10'h2ff, "R6 flow read bank 2");
    flow_read(1'b0, 10'h2ff, "R7 gated zero");

    // R10: combinational reads leave the capture registers alone.
    @(negedge rd_clk); rd_async = 1'b0; rd_en = 1'b0;
    #1;
    check("R10 registered value kept", rd_data, exp_sync);

    // R9: same-edge collision with a shared clock.
    lockstep = 1'b1;
    begin
      logic [DW-1:0] old_w;
      old_w = model[10'h1aa];
      @(negedge wr_clk);
      wr_en = 1'b1; wr_addr = 10'h1aa; wr_data = 18'h3c3c3;
      rd_async = 1'b0; rd_en = 1'b1; rd_addr = 10'h1aa;
      @(posedge wr_clk);
      #1;
      model[10'h1aa] = 18'h3c3c3;
      @(negedge wr_clk);
      wr_en = 1'b0; rd_en = 1'b0;
      check("R9 collision returns old", rd_data, old_w);
      sync_read(10'h1aa, "R9 later read new");
    end
    lockstep = 1'b0;

    // Random mix across banks and modes with unrelated clocks.
    for (int n = 0; n < 800; n++) begin
      int unsigned kind;
      logic [AW-1:0] a;
      kind = $urandom_range(0, 3);
      a = AW'($urandom);
      case (kind)
        0: do_write(1'($urandom), a, DW'($urandom));
        1: sync_read(a, "R4 random registered read");
        2: flow_read(1'b1, a, "R6 random flow read");
        default: flow_read(1'b0, a, "R7 random gated read");
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule